// File: doc/BRIEF.md
# Issue Queue Reuse Pointer Scanner

While a captured loop is being replayed out of the issue queue, the fetch and decode stages are gated off. This block takes their place as the instruction source. It holds a pointer into the buffered region of the queue. Every cycle it looks at a window of `N` consecutive entries starting at that pointer. When every buffered entry in the window has issued, it sends the entries' logical register numbers to rename and marks those entries for an issue-state clear. The rename tags that come back one cycle later are steered to the same entries.

The buffered region is circular. It runs from `region_first` to `region_last`, modulo the queue depth, and may wrap past the top of the queue. When the pointer reaches the end of the region it returns to the first buffered entry, so the loop body repeats without limit. A branch in the replayed body is not looked up in the dynamic predictor. It is predicted in the direction it took when it was buffered. The external branch check raises `abort` on a mispredict. Scanning then stops at once, and the pointer is parked at the region start.

Top module: `iq_reuse_scanner`

## Requirements
- R1: Each cycle the window covers queue entries `ptr+k` (mod DEPTH) for k = 0..N-1. The window is sent only if every in-region entry in it has its `entry_issued` bit at 1. Otherwise `rn_valid` is all zero that cycle and `ptr` holds.
- R2: A sent window that does not reach the last buffered entry advances `ptr` by N (mod DEPTH) at the next clock edge.
- R3: Suppose the remaining region length R from `ptr` to `region_last` is at most N. Then only the low R slots are valid, as a mask of contiguous ones starting at slot 0. Out-of-region entries in the window are ignored, including whether they have issued. `ptr` returns to `region_first` at the next edge.
- R4: Valid slot k carries `rn_idx` = ptr+k (mod DEPTH) and that entry's three logical register fields. `clr_issued` has a 1 exactly at the indices of the sent entries.
- R5: For each valid slot, `rn_is_br` copies the entry's branch flag. `rn_pred_taken` is the recorded direction bit ANDed with the branch flag. There is no other prediction input.
- R6: One cycle after a send, `rt_valid` returns the rename result. For each slot that was sent and is marked in `rt_valid`, `wb_valid` is 1, `wb_idx` repeats the index sent in the previous cycle, and `wb_tags` carries the returned tags. If no send happened in the previous cycle, `wb_valid` stays 0.
- R7: With `abort` high, nothing is sent and no writeback is reported in that cycle, and `ptr` becomes `region_first` at the next edge.
- R8: With `reuse_en` low, nothing is sent and `ptr` is loaded with `region_first`, so replay always starts at the first buffered entry.
- R9: A region with `region_first` > `region_last` wraps past the top of the queue. `region_last` = `region_first`-1 (mod DEPTH) covers all DEPTH entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reuse_en | input | 1 | Replay state active |
| abort | input | 1 | Mispredict reported, leave replay |
| region_first | input | IW | First buffered entry |
| region_last | input | IW | Last buffered entry |
| entry_issued | input | DEPTH | Issue-state bit per queue entry |
| entry_lregs | input | DEPTH*3*RW | Logical register fields per entry (dest, src0, src1) |
| entry_br | input | DEPTH | Entry holds a branch |
| entry_taken | input | DEPTH | Direction recorded at buffering |
| rn_valid | output | N | Slot valid mask to rename |
| rn_idx | output | N*IW | Queue index per slot |
| rn_lregs | output | N*3*RW | Logical register fields per slot |
| rn_is_br | output | N | Slot is a branch |
| rn_pred_taken | output | N | Static prediction per slot |
| clr_issued | output | DEPTH | Issue-state clear strobe per entry |
| ptr | output | IW | Current reuse pointer |
| rt_valid | input | N | Rename result valid per slot |
| rt_tags | input | N*3*TW | Renamed tags per slot |
| wb_valid | output | N | Tag writeback valid per slot |
| wb_idx | output | N*IW | Target entry per writeback slot |
| wb_tags | output | N*3*TW | Tags to write |

## Verification
The assertions assume three things about the inputs. `ptr` stays inside the region between `region_first` and `region_last`, which means the region bounds do not change while `reuse_en` is high. N is no larger than DEPTH. Rename answers exactly one cycle after a send. The stimulus meets all three: it changes the bounds only while `reuse_en` is low, so the pointer is reloaded first, and it raises `rt_valid` only in the cycle after a window goes out, apart from one deliberate case with no preceding send. The sweep covers every pair of region bounds in an 8-entry queue. It adds targeted stalls, a not-issued entry outside the region, aborts, and writeback timing.

// File: rtl/iq_reuse_scanner.sv
module iq_reuse_scanner #(
  parameter int DEPTH = 16,
  parameter int N     = 4,
  parameter int RW    = 5,
  parameter int TW    = 7,
  localparam int IW   = $clog2(DEPTH),
  localparam int LW   = 3 * RW,
  localparam int SW   = 3 * TW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reuse_en,
  input  logic                 abort,
  input  logic [IW-1:0]        region_first,
  input  logic [IW-1:0]        region_last,
  input  logic [DEPTH-1:0]     entry_issued,
  input  logic [DEPTH*LW-1:0]  entry_lregs,
  input  logic [DEPTH-1:0]     entry_br,
  input  logic [DEPTH-1:0]     entry_taken,
  output logic [N-1:0]         rn_valid,
  output logic [N*IW-1:0]      rn_idx,
  output logic [N*LW-1:0]      rn_lregs,
  output logic [N-1:0]         rn_is_br,
  output logic [N-1:0]         rn_pred_taken,
  output logic [DEPTH-1:0]     clr_issued,
  output logic [IW-1:0]        ptr,
  input  logic [N-1:0]         rt_valid,
  input  logic [N*SW-1:0]      rt_tags,
  output logic [N-1:0]         wb_valid,
  output logic [N*IW-1:0]      wb_idx,
  output logic [N*SW-1:0]      wb_tags
);

  logic [IW-1:0]   ptr_q;
  logic [IW:0]     region_len, offset, remain;
  logic [N-1:0]    in_reg, ready_k;
  logic [IW-1:0]   idx [N];
  logic            wrap, go;
  logic [N-1:0]    held_mask;
  logic [N*IW-1:0] held_idx;

  assign region_len = {1'b0, IW'(region_last - region_first)} + 1'b1;
  assign offset     = {1'b0, IW'(ptr_q - region_first)};
  assign remain     = region_len - offset;
  assign wrap       = remain <= (IW+1)'(N);
  assign go         = reuse_en & ~abort & (&ready_k);
  assign rn_valid   = go ? in_reg : '0;
  assign ptr        = ptr_q;

  for (genvar k = 0; k < N; k++) begin : g_slot
    assign idx[k]       = ptr_q + IW'(k);
    assign in_reg[k]    = remain > (IW+1)'(k);
    assign ready_k[k]   = ~in_reg[k] | entry_issued[idx[k]];
    assign rn_idx[k*IW +: IW]   = idx[k];
    assign rn_lregs[k*LW +: LW] = entry_lregs[int'(idx[k])*LW +: LW];
    assign rn_is_br[k]          = entry_br[idx[k]];
    assign rn_pred_taken[k]     = entry_br[idx[k]] & entry_taken[idx[k]];

    a_r1_sent_only_issued: assert property (@(posedge clk) disable iff (!rst_n)
      rn_valid[k] |-> entry_issued[idx[k]]);
    a_r6_wb_follows_send: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid[k] |-> $past(rn_valid[k]));
  end

  always_comb begin
    clr_issued = '0;
    for (int k = 0; k < N; k++)
      if (rn_valid[k]) clr_issued[idx[k]] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q     <= '0;
      held_mask <= '0;
      held_idx  <= '0;
    end else begin
      if (!reuse_en || abort) ptr_q <= region_first;
      else if (go)            ptr_q <= wrap ? region_first : ptr_q + IW'(N);
      held_mask <= rn_valid;
      held_idx  <= rn_idx;
    end
  end

  assign wb_valid = held_mask & rt_valid & {N{~abort}};
  assign wb_idx   = held_idx;
  assign wb_tags  = rt_tags;

  a_r2_advance_by_n: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !wrap) |=> ptr_q == $past(ptr_q) + IW'(N));
  a_r3_wrap_to_first: assert property (@(posedge clk) disable iff (!rst_n)
    (go && wrap) |=> ptr_q == $past(region_first));
  a_r3_mask_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
    ((rn_valid + 1'b1) & rn_valid) == '0);
  a_r4_clear_count: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(clr_issued) == $countones(rn_valid));
  a_r7_abort_silent: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> (rn_valid == '0 && wb_valid == '0));
  a_r7_park_pointer: assert property (@(posedge clk) disable iff (!rst_n)
    (!reuse_en || abort) |=> ptr_q == $past(region_first));
  a_r8_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !reuse_en |-> rn_valid == '0);

endmodule

// File: tb/sim_iq_reuse_scanner.sv
module sim_iq_reuse_scanner;
  localparam int DEPTH = 8, N = 4, RW = 3, TW = 4;
  localparam int IW = 3, LW = 9, SW = 12;

  logic clk = 0, rst_n = 0, reuse_en = 0, abort = 0;
  logic [IW-1:0] region_first = 0, region_last = 0;
  logic [DEPTH-1:0] entry_issued = '1, entry_br = 8'b0101_0110, entry_taken = 8'b0011_1010;
  logic [DEPTH*LW-1:0] entry_lregs;
  logic [N-1:0] rn_valid, rn_is_br, rn_pred_taken, rt_valid = 0, wb_valid;
  logic [N*IW-1:0] rn_idx, wb_idx;
  logic [N*LW-1:0] rn_lregs;
  logic [DEPTH-1:0] clr_issued;
  logic [IW-1:0] ptr;
  logic [N*SW-1:0] rt_tags = 0, wb_tags;
  int tests = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  iq_reuse_scanner #(.DEPTH(DEPTH), .N(N), .RW(RW), .TW(TW)) u0 (
    .clk, .rst_n, .reuse_en, .abort, .region_first, .region_last, .entry_issued,
    .entry_lregs, .entry_br, .entry_taken, .rn_valid, .rn_idx, .rn_lregs, .rn_is_br,
    .rn_pred_taken, .clr_issued, .ptr, .rt_valid, .rt_tags, .wb_valid, .wb_idx, .wb_tags);

  function automatic logic [LW-1:0] lregs_of(int i);
    return {3'((i*3+3)&7), 3'((i*3+2)&7), 3'((i*3+1)&7)};
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    #(8*200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1 act=hung exp=done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [N-1:0] m_prev;
    logic [N*IW-1:0] i_prev;
    for (int i = 0; i < DEPTH; i++) entry_lregs[i*LW +: LW] = lregs_of(i);
    repeat (3) @(negedge clk);
    #1 chk(rn_valid == 0, "R8 reset", rn_valid, 0);
    chk(wb_valid == 0, "R6 reset", wb_valid, 0);
    rst_n = 1;

    for (int f = 0; f < DEPTH; f++) for (int l = 0; l < DEPTH; l++) begin
      int len, o, ncyc;
      @(negedge clk);
      reuse_en = 0; region_first = IW'(f); region_last = IW'(l); entry_issued = '1;
      #1 chk(rn_valid == 0, "R8 idle", rn_valid, 0);
      @(negedge clk);
      #1 chk(ptr == IW'(f), "R8 load", ptr, f);
      reuse_en = 1;
      len = ((l - f) & 7) + 1;
      o = 0;
      ncyc = 2 * ((len + N - 1) / N) + 1;
      for (int c = 0; c < ncyc; c++) begin
        int cnt;
        logic [DEPTH-1:0] cexp;
        #1;
        cnt = (len - o < N) ? len - o : N;
        chk(ptr == IW'((f + o) & 7), "R2 ptr", ptr, (f + o) & 7);
        chk(rn_valid == N'((1 << cnt) - 1), cnt < N ? "R3 mask" : "R1 mask", rn_valid, (1 << cnt) - 1);
        cexp = '0;
        for (int k = 0; k < cnt; k++) begin
          int e;
          e = (f + o + k) & 7;
          cexp[e] = 1'b1;
          chk(rn_idx[k*IW +: IW] == IW'(e), f > l ? "R9 idx" : "R4 idx", rn_idx[k*IW +: IW], e);
          chk(rn_lregs[k*LW +: LW] == lregs_of(e), "R4 lregs", rn_lregs[k*LW +: LW], lregs_of(e));
          chk(rn_is_br[k] == entry_br[e] && rn_pred_taken[k] == (entry_br[e] & entry_taken[e]),
              "R5 pred", {rn_is_br[k], rn_pred_taken[k]}, {entry_br[e], entry_br[e] & entry_taken[e]});
        end
        chk(clr_issued == cexp, "R4 clr", clr_issued, cexp);
        o = (o + N >= len) ? 0 : o + N;
        @(negedge clk);
      end
    end

    // stall and out-of-region cases: region 2..6
    reuse_en = 0; region_first = 2; region_last = 6;
    @(negedge clk); reuse_en = 1; entry_issued = 8'b1110_1111;
    #1 chk(rn_valid == 0, "R1 stall", rn_valid, 0);
    @(negedge clk); #1 chk(ptr == 2, "R1 hold", ptr, 2);
    entry_issued = 8'b0111_1111;
    #1 chk(rn_valid == 4'hF, "R1 resume", rn_valid, 4'hF);
    @(negedge clk); #1 chk(ptr == 6, "R2 step", ptr, 6);
    chk(rn_valid == 4'h1, "R3 outside ignored", rn_valid, 1);
    @(negedge clk); #1 chk(ptr == 2, "R3 wrap", ptr, 2);

    // writeback timing
    entry_issued = '1;
    m_prev = rn_valid; i_prev = rn_idx;
    @(negedge clk);
    rt_valid = 4'hF; rt_tags = 48'hABC_DEF_123_456;
    #1 chk(wb_valid == m_prev, "R6 wb valid", wb_valid, m_prev);
    chk(wb_idx == i_prev, "R6 wb idx", wb_idx, i_prev);
    chk(wb_tags == rt_tags, "R6 wb tags", wb_tags, rt_tags);
    // abort in the writeback cycle kills both send and writeback
    abort = 1;
    #1 chk(wb_valid == 0, "R7 wb kill", wb_valid, 0);
    chk(rn_valid == 0, "R7 no send", rn_valid, 0);
    @(negedge clk); abort = 0; rt_valid = 0;
    #1 chk(ptr == 2, "R7 park", ptr, 2);
    // rename result with no preceding send
    reuse_en = 0;
    @(negedge clk); rt_valid = 4'hF;
    #1 chk(wb_valid == 0, "R6 no send", wb_valid, 0);
    rt_valid = 0;

    done = 1;
    summary();
    $finish;
  end
endmodule